// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 10-bit successive-approximation converter. Software uses a small register window to set it up and start it. The window holds one control/status word and four result words. A conversion can also be started by a rising edge on an external trigger pin.

The block runs the binary search over the trial codes it drives to an external DAC, using a one-bit comparator answer that comes back. It stores the 10-bit outcome in the result word that belongs to the converted channel, then raises a done flag. When enabled, that flag produces a level interrupt. The block converts one channel once per start. Repeated scanning of channels is not part of it.

The done flag is protected against a stray clear. A write of 0 clears it only after software has read the status word while the flag was set. Writing 0 to the start bit while a conversion runs abandons that conversion and leaves no trace.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control/status word, all four result words, `irq` and `dac_code` are all zero.
- R2: The control/status word sits at address 0. Its bits are: bit 0 start/busy, bit 1 done flag, bit 2 interrupt enable, bit 3 mode (0 = single), bits 6:4 channel. Enable, mode and channel read back as last written.
- R3: A write to address 0 with bit 0 = 1 and bit 3 = 0 starts a conversion when idle. Bit 0 then reads 1 for exactly 11 cycles after the write edge and returns to 0 by itself. A start write during a conversion does not restart it.
- R4: Bits are resolved from bit 9 down to bit 0, one per cycle. During each trial cycle, `dac_code` shows the bits already decided plus the current trial bit. The trial bit is kept when `cmp_hi` is 1, meaning the input is at or above `dac_code`. The final result equals the input code for an ideal comparator.
- R5: When a conversion completes, the result goes to address 4 + channel[1:0], so channels 0 and 4 share address 4, and so on. In the same edge the done flag sets and bit 0 clears. Other result words are unchanged.
- R6: `irq` is high exactly when the done flag and the enable bit are both 1.
- R7: A write to address 0 with bit 1 = 0 clears the done flag only if an earlier read of address 0 (with `bus_rd`) saw the flag set. Without that read, or with bit 1 written as 1, the flag stays set.
- R8: Writing bit 0 = 0 during a conversion abandons it within one cycle. The result words and the done flag are left unchanged.
- R9: The destination channel is the one carried in the start write. Channel writes made while a conversion runs do not change where its result goes.
- R10: `ext_trig` passes through a two-flop synchronizer and an edge detector. A rising edge starts a conversion on the stored channel, with busy visible three edges after the pin rises. A rising edge that arrives during a conversion is ignored.
- R11: Start requests are ignored while the mode bit is 1. This covers a software start written together with mode = 1, and a trigger while the stored mode is 1.
- R12: From the start edge, `chan_sel` holds the channel of the running conversion and keeps it until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (only address 0 is writable) |
| bus_rd | input | 1 | Read strobe; needed to arm the done-flag clear |
| bus_addr | input | 3 | Register address: 0 status word, 4..7 result words |
| bus_wdata | input | 7 | Write data for the control/status word |
| bus_rdata | output | 10 | Read data for `bus_addr`, combinational |
| ext_trig | input | 1 | Asynchronous external start request |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 3 | Analog channel select |
| irq | output | 1 | Interrupt request level |

## Verification
The search is driven with the input codes 37, 512, 1023, 0 and 682. These separate a correct MSB-first decision rule from an inverted or off-by-one one: 1023 and 0 keep or reject every trial, 512 keeps only the top bit, and 682 alternates. Channels 1, 3, 5, 6 and 4 are used so that a result landing in the wrong word shows up. Channels 4 and 5 in particular show whether the two low bits alone pick the word. Separate patterns cover the following:
- the done-flag clear with and without the arming read;
- an abort part-way through a search;
- a channel rewrite during a conversion;
- a trigger edge that lands inside a conversion;
- starts attempted with the mode bit set.

A behavioural model compares the read data, `dac_code`, `chan_sel` and `irq` every cycle.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int SAR_RES_W    = 10;
  localparam int SAR_CH_W     = 3;
  localparam int SAR_NRES     = 4;
  localparam int SAR_ADDR_W   = 3;
  localparam int SAR_SYNC_N   = 2;

  localparam int CSR_GO_BIT   = 0;
  localparam int CSR_DONE_BIT = 1;
  localparam int CSR_IE_BIT   = 2;
  localparam int CSR_MODE_BIT = 3;
  localparam int CSR_CH_LSB   = 4;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_TRIAL = 2'd1,
    ENG_STORE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/sar_trig_sync.sv
`timescale 1ns/1ps
module sar_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d[0] = trig_i;
    for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // An edge pulse lasts exactly one cycle.
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sar_engine.sv
`timescale 1ns/1ps
module sar_engine
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CH_W-1:0]  start_ch_i,
  input  logic             abort_i,
  input  logic             cmp_hi_i,
  output logic             busy_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             store_o,
  output logic [IDX_W-1:0] store_idx_o,
  output logic [RES_W-1:0] store_data_o
);
  localparam int POS_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [POS_W-1:0] POS_TOP = POS_W'(RES_W - 1);

  eng_state_e       state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [RES_W-1:0] acc_q, acc_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [RES_W-1:0] trial_bit;
  logic             eng_en;
  logic             store_d;

  assign trial_bit = RES_W'(1) << pos_q;
  assign eng_en    = (state_q != ENG_IDLE) | start_i;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    acc_d   = acc_q;
    ch_d    = ch_q;
    store_d = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start_i) begin
          state_d = ENG_TRIAL;
          pos_d   = POS_TOP;
          acc_d   = '0;
          ch_d    = start_ch_i;
        end
      end
      ENG_TRIAL: begin
        if (abort_i) begin
          state_d = ENG_IDLE;
        end else begin
          if (cmp_hi_i) acc_d = acc_q | trial_bit;
          if (pos_q == '0) state_d = ENG_STORE;
          else             pos_d   = pos_q - POS_W'(1);
        end
      end
      ENG_STORE: begin
        state_d = ENG_IDLE;
        store_d = ~abort_i;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      pos_q   <= '0;
      acc_q   <= '0;
      ch_q    <= '0;
    end else if (eng_en) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      acc_q   <= acc_d;
      ch_q    <= ch_d;
    end
  end

  assign busy_o       = (state_q != ENG_IDLE);
  assign dac_code_o   = (state_q == ENG_TRIAL) ? (acc_q | trial_bit) : acc_q;
  assign chan_o       = ch_q;
  assign store_o      = store_d;
  assign store_idx_o  = ch_q[IDX_W-1:0];
  assign store_data_o = acc_q;

  assert_start_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ENG_IDLE) |=> busy_o);

  // A conversion ends only through its store cycle or an abort.
  assert_end_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(abort_i || state_q == ENG_STORE));

  // Exactly one undecided bit is on trial at a time.
  assert_one_trial_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_TRIAL) |-> ($countones(dac_code_o & ~acc_q) == 1));

  assert_chan_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(chan_o));
endmodule

// File: rtl/sar_result_bank.sv
`timescale 1ns/1ps
module sar_result_bank #(
  parameter int NREG  = 4,
  parameter int W     = 10,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rd_data_o
);
  logic [W-1:0]    bank_q [NREG];
  logic [NREG-1:0] wen;

  for (genvar g = 0; g < NREG; g++) begin : g_wen
    assign wen[g] = wr_i && (wr_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wen[i]) bank_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = bank_q[rd_idx_i];

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (bank_q[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/sar_csr.sv
`timescale 1ns/1ps
module sar_csr
  import sar_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [CSR_CH_LSB+CH_W-1:0] bus_wdata,
  output logic [RES_W-1:0]           bus_rdata,
  input  logic                       busy_i,
  input  logic                       store_i,
  input  logic                       trig_rise_i,
  input  logic [RES_W-1:0]           res_data_i,
  output logic [IDX_W-1:0]           res_idx_o,
  output logic                       start_o,
  output logic [CH_W-1:0]            start_ch_o,
  output logic                       abort_o,
  output logic                       irq_o
);
  logic            done_q, done_d;
  logic            armed_q, armed_d;
  logic            ie_q, mode_q;
  logic [CH_W-1:0] ch_q;
  logic            csr_hit, wr_csr, rd_csr;
  logic            w_go, w_done, w_ie, w_mode;
  logic [CH_W-1:0] w_ch;
  logic            sw_start, hw_start, done_clr, flag_en;
  logic [RES_W-1:0] csr_word;

  assign csr_hit = (bus_addr == '0);
  assign wr_csr  = bus_sel & bus_wr & csr_hit;
  assign rd_csr  = bus_sel & bus_rd & csr_hit;

  assign w_go   = bus_wdata[CSR_GO_BIT];
  assign w_done = bus_wdata[CSR_DONE_BIT];
  assign w_ie   = bus_wdata[CSR_IE_BIT];
  assign w_mode = bus_wdata[CSR_MODE_BIT];
  assign w_ch   = bus_wdata[CSR_CH_LSB +: CH_W];

  assign sw_start   = wr_csr & w_go & ~w_mode & ~busy_i;
  assign hw_start   = trig_rise_i & ~mode_q & ~busy_i;
  assign start_o    = sw_start | hw_start;
  assign start_ch_o = sw_start ? w_ch : ch_q;
  assign abort_o    = wr_csr & ~w_go & busy_i;

  assign done_clr = wr_csr & ~w_done & armed_q & ~store_i;
  assign flag_en  = store_i | done_clr | rd_csr;

  always_comb begin
    done_d  = done_q;
    armed_d = armed_q;
    if (store_i) begin
      done_d = 1'b1;
    end else if (done_clr) begin
      done_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (rd_csr && done_q && !done_clr) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (flag_en) begin
      done_q  <= done_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mode_q <= 1'b0;
      ch_q   <= '0;
    end else if (wr_csr) begin
      ie_q   <= w_ie;
      mode_q <= w_mode;
      ch_q   <= w_ch;
    end
  end

  always_comb begin
    csr_word = '0;
    csr_word[CSR_GO_BIT]          = busy_i;
    csr_word[CSR_DONE_BIT]        = done_q;
    csr_word[CSR_IE_BIT]          = ie_q;
    csr_word[CSR_MODE_BIT]        = mode_q;
    csr_word[CSR_CH_LSB +: CH_W]  = ch_q;
  end

  assign res_idx_o = bus_addr[IDX_W-1:0];
  assign bus_rdata = csr_hit ? csr_word :
                     (bus_addr[ADDR_W-1] ? res_data_i : '0);
  assign irq_o     = done_q & ie_q;

  assert_done_needs_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(store_i));

  assert_clear_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_q) |-> $past(armed_q));

  assert_irq_on_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && ie_q && !wr_csr) |=> irq_o);

  assert_mode_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !wr_csr) |-> !start_o);
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W  = SAR_RES_W,
  parameter int CH_W   = SAR_CH_W,
  parameter int NRES   = SAR_NRES,
  parameter int ADDR_W = SAR_ADDR_W,
  parameter int SYNC_N = SAR_SYNC_N
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [CSR_CH_LSB+CH_W-1:0] bus_wdata,
  output logic [RES_W-1:0]           bus_rdata,
  input  logic                       ext_trig,
  input  logic                       cmp_hi,
  output logic [RES_W-1:0]           dac_code,
  output logic [CH_W-1:0]            chan_sel,
  output logic                       irq
);
  localparam int IDX_W = (NRES > 1) ? $clog2(NRES) : 1;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             trig_rise, start, abort, busy, store;
  logic [CH_W-1:0]  start_ch;
  logic [IDX_W-1:0] store_idx, rd_idx;
  logic [RES_W-1:0] store_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  sar_trig_sync #(.STAGES(SYNC_N)) u_trig (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .trig_i (ext_trig),
    .rise_o (trig_rise)
  );

  sar_csr #(.RES_W(RES_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .busy_i      (busy),
    .store_i     (store),
    .trig_rise_i (trig_rise),
    .res_data_i  (rd_data),
    .res_idx_o   (rd_idx),
    .start_o     (start),
    .start_ch_o  (start_ch),
    .abort_o     (abort),
    .irq_o       (irq)
  );

  sar_engine #(.RES_W(RES_W), .CH_W(CH_W), .IDX_W(IDX_W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start),
    .start_ch_i   (start_ch),
    .abort_i      (abort),
    .cmp_hi_i     (cmp_hi),
    .busy_o       (busy),
    .dac_code_o   (dac_code),
    .chan_o       (chan_sel),
    .store_o      (store),
    .store_idx_o  (store_idx),
    .store_data_o (store_data)
  );

  sar_result_bank #(.NREG(NRES), .W(RES_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_i      (store),
    .wr_idx_i  (store_idx),
    .wr_data_i (store_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );
endmodule

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/1ps
module sim_sar_adc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [6:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  logic       ext_trig = 1'b0;
  logic       cmp_hi;
  logic [9:0] dac_code;
  logic [2:0] chan_sel;
  logic       irq;

  int vin = 0;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit chk_on = 0;

  always #2 clk = ~clk;

  assign cmp_hi = (vin >= int'(dac_code));

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_trig(ext_trig), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .chan_sel(chan_sel), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_state, m_pos, m_acc, m_ch, m_done, m_arm, m_ie, m_mode, m_chreg;
  int m_res[4];
  int m_s1, m_s2, m_prev;
  int t_busy, t_wr, t_rd, t_rise, t_sw, t_tr, t_ab, t_st, t_cmp, t_clr;

  function automatic int m_dac();
    return (m_state == 1) ? (m_acc | (1 << m_pos)) : m_acc;
  endfunction

  function automatic int m_rdata(input int a);
    if (a == 0)
      return (m_chreg << 4) | (m_mode << 3) | (m_ie << 2) | (m_done << 1) | int'(m_state != 0);
    if (a >= 4) return m_res[a-4];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pos = 0; m_acc = 0; m_ch = 0; m_done = 0; m_arm = 0;
      m_ie = 0; m_mode = 0; m_chreg = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      for (int i = 0; i < 4; i++) m_res[i] = 0;
    end else begin
      t_busy = int'(m_state != 0);
      t_wr   = int'(bus_sel && bus_wr && bus_addr == 0);
      t_rd   = int'(bus_sel && bus_rd && bus_addr == 0);
      t_rise = int'(m_s2 == 1 && m_prev == 0);
      t_sw   = int'(t_wr == 1 && bus_wdata[0] && !bus_wdata[3] && t_busy == 0);
      t_tr   = int'(t_rise == 1 && m_mode == 0 && t_busy == 0);
      t_ab   = int'(t_wr == 1 && !bus_wdata[0] && t_busy == 1);
      t_st   = int'(m_state == 2 && t_ab == 0);
      t_cmp  = int'(vin >= m_dac());
      t_clr  = int'(t_wr == 1 && !bus_wdata[1] && m_arm == 1 && t_st == 0);
      // flags
      if (t_st == 1) m_done = 1;
      else if (t_clr == 1) begin m_done = 0; m_arm = 0; end
      if (t_rd == 1 && m_done == 1 && t_clr == 0 && t_st == 0) m_arm = 1;
      else if (t_rd == 1 && t_st == 1 && t_busy == 1 && m_done == 1) m_arm = 1;
      // search
      if (m_state == 0) begin
        if (t_sw == 1 || t_tr == 1) begin
          m_state = 1; m_pos = 9; m_acc = 0;
          m_ch = (t_sw == 1) ? int'(bus_wdata[6:4]) : m_chreg;
        end
      end else if (m_state == 1) begin
        if (t_ab == 1) m_state = 0;
        else begin
          if (t_cmp == 1) m_acc = m_acc | (1 << m_pos);
          if (m_pos == 0) m_state = 2; else m_pos = m_pos - 1;
        end
      end else begin
        m_state = 0;
        if (t_st == 1) m_res[m_ch % 4] = m_acc;
      end
      if (t_wr == 1) begin
        m_ie = int'(bus_wdata[2]); m_mode = int'(bus_wdata[3]); m_chreg = int'(bus_wdata[6:4]);
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(ext_trig);
    end
  end

  task automatic expect_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      expect_eq(int'(bus_rdata), m_rdata(int'(bus_addr)), (bus_addr == 0) ? "R2 status word vs model" : "R5 result word vs model");
      expect_eq(int'(dac_code), m_dac(), "R4 dac_code vs model");
      expect_eq(int'(irq), int'(m_done == 1 && m_ie == 1), "R6 irq vs model");
      expect_eq(int'(chan_sel), m_ch, "R12 chan_sel vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R3 watchdog actual %0d expected below %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [6:0] cw(input int go, input int dn, input int ie, input int md, input int ch);
    return {3'(ch), 1'(md), 1'(ie), 1'(dn), 1'(go)};
  endfunction

  task automatic wr_csr(input logic [6:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_csr();
    @(posedge clk); #1;
    bus_sel = 1; bus_rd = 1; bus_addr = 0;
    @(posedge clk); #1;
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic peek(input int a, output int v);
    @(posedge clk); #1;
    bus_addr = 3'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wait_done();
    int v;
    for (int i = 0; i < 40; i++) begin
      peek(0, v);
      if ((v & 1) == 0) break;
    end
  endtask

  task automatic clear_done(input int ie, input int md, input int ch);
    rd_csr();
    wr_csr(cw(0, 0, ie, md, ch));
  endtask

  task automatic pulse_trig(input int n);
    @(posedge clk); #1; ext_trig = 1;
    wait_cycles(n);
    #1; ext_trig = 0;
  endtask

  initial begin
    int v;
    int n;
    wait_cycles(3);
    #1; rst_n = 1;
    wait_cycles(4);
    chk_on = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      if (a == 0 || a >= 4) begin
        peek(a, v);
        expect_eq(v, 0, "R1 register after reset");
      end
    end
    expect_eq(int'(irq), 0, "R1 irq after reset");
    expect_eq(int'(dac_code), 0, "R1 dac_code after reset");

    // R3 / R5 / R6 software start on channel 1
    vin = 37;
    wr_csr(cw(1, 0, 1, 0, 1));
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) n++;
      else break;
    end
    expect_eq(n, 11, "R3 start bit high cycles");
    expect_eq(int'(bus_rdata[1]), 1, "R5 done set as start clears");
    expect_eq(int'(irq), 1, "R6 irq with done and enable");
    peek(5, v); expect_eq(v, 37, "R5 result of channel 1");
    peek(4, v); expect_eq(v, 0, "R5 other result untouched");

    // R7 clear needs an armed read
    wr_csr(cw(0, 0, 1, 0, 1));
    peek(0, v); expect_eq((v >> 1) & 1, 1, "R7 unarmed clear ignored");
    rd_csr();
    wr_csr(cw(0, 1, 1, 0, 1));
    peek(0, v); expect_eq((v >> 1) & 1, 1, "R7 write of one keeps flag");
    wr_csr(cw(0, 0, 1, 0, 1));
    peek(0, v); expect_eq((v >> 1) & 1, 0, "R7 armed clear");
    expect_eq(int'(irq), 0, "R6 irq drops with flag");

    // R8 abort
    vin = 700;
    wr_csr(cw(1, 0, 1, 0, 2));
    wait_cycles(4);
    wr_csr(cw(0, 0, 1, 0, 2));
    wait_cycles(15);
    peek(0, v); expect_eq(v, 'h24, "R8 idle and no flag after abort");
    peek(6, v); expect_eq(v, 0, "R8 result untouched by abort");

    // R9 channel rewrite during conversion
    vin = 512;
    wr_csr(cw(1, 0, 0, 0, 3));
    wait_cycles(2);
    wr_csr(cw(1, 0, 0, 0, 0));
    @(negedge clk); expect_eq(int'(chan_sel), 3, "R12 chan_sel holds running channel");
    wait_done();
    peek(7, v); expect_eq(v, 512, "R9 result to start channel");
    peek(4, v); expect_eq(v, 0, "R9 rewritten channel untouched");
    peek(0, v); expect_eq(v, 2, "R2 status word read back");
    clear_done(0, 0, 0);

    // R10 trigger, second edge inside the conversion
    wr_csr(cw(0, 0, 1, 0, 6));
    vin = 1023;
    pulse_trig(3);
    wait_cycles(3);
    pulse_trig(2);
    wait_cycles(25);
    peek(0, v); expect_eq(v & 1, 0, "R10 trigger during conversion ignored");
    peek(6, v); expect_eq(v, 1023, "R10 triggered result");
    clear_done(1, 0, 6);

    // R11 mode bit blocks starts
    vin = 100;
    wr_csr(cw(1, 0, 1, 1, 0));
    peek(0, v); expect_eq(v & 1, 0, "R11 software start with mode 1");
    pulse_trig(3);
    wait_cycles(15);
    peek(0, v); expect_eq(v, 'h0C, "R11 trigger with mode 1");
    peek(4, v); expect_eq(v, 0, "R11 no result written");

    // R4 extreme and alternating codes, shared words
    vin = 0;
    wr_csr(cw(1, 0, 0, 0, 5));
    wait_done();
    peek(5, v); expect_eq(v, 0, "R4 all trials rejected, channel 5 to word 1");
    clear_done(0, 0, 5);
    vin = 682;
    wr_csr(cw(1, 0, 0, 0, 4));
    wait_done();
    peek(4, v); expect_eq(v, 682, "R4 alternating code, channel 4 to word 0");
    clear_done(0, 0, 4);
    wait_cycles(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule